// File: doc/BRIEF.md
# Programmable Clock Ratio Generator

This block runs on a single fast base clock and produces three periodic clock-enable strobes: one for the core domain, one for the bus domain and one for the peripheral domain. Each strobe is a one-cycle pulse that repeats every N base cycles. N comes from a 3-bit code in a frequency-control register. Each code is looked up in a fixed, non-power-of-two table. When the register's PLL-enable bit is clear, a further divide-by-6 prescale applies. Logic in each domain qualifies its flops with its strobe, so no derived clocks are needed. The block also reports the total divide ratio now in force for each domain.

A simple write port loads the control register and a small bank of spare registers. A combinational read port returns the content of any register. Writing the control register restarts all three divide counters together, so the new ratios start from a common phase. A small sequencer has two named states. ST_WAIT is held during reset and for the first cycle after it, and all strobes are low there. The transition WAIT_TO_RUN is taken unconditionally on the first clock edge after reset. ST_RUN then persists, with the self-transition RUN_HOLD, until the next reset.

Top module: `clk_ratio_gen`

## Requirements
- R1: After reset the control register reads 0x0E0A, and the reported ratios are core 1, bus 2 and peripheral 4. All strobes are low in the first cycle after reset is released (state ST_WAIT). All strobes are high in the cycle after that (state ST_RUN, phase 0).
- R2: The core code is control bits 8:6. Codes 0..7 map to the core divider values 1,2,3,4,5,8,8,8.
- R3: The bus code is control bits 5:3. It uses the same map as the core code: 1,2,3,4,5,8,8,8.
- R4: The peripheral code is control bits 2:0. Codes 0..7 map to the divider values 2,3,4,6,8,8,8,8.
- R5: Control bit 10 is the PLL-enable bit. When it is 0, every reported ratio is six times its table value. When it is 1, the reported ratio equals the table value.
- R6: In ST_RUN each strobe is high for exactly one cycle out of every N cycles, where N is that domain's reported ratio. A ratio of 1 keeps the strobe high continuously.
- R7: A write to the control register (address 0) makes all three strobes high in the cycle after the write edge. Each strobe then continues with its new spacing from that common phase.
- R8: A write to any address other than 0 is stored, but it changes neither the control register, the reported ratios nor the strobe phase.
- R9: rd_data combinationally returns the stored content of the register selected by rd_addr. Spare registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Write address; 0 is the control register |
| wr_data | input | DATA_W (16) | Write data |
| rd_addr | input | ADDR_W (2) | Read address |
| rd_data | output | DATA_W (16) | Content of the addressed register |
| core_stb | output | 1 | Core-domain clock-enable pulse |
| bus_stb | output | 1 | Bus-domain clock-enable pulse |
| periph_stb | output | 1 | Peripheral-domain clock-enable pulse |
| core_ratio | output | RATIO_W (6) | Core divide ratio now in force |
| bus_ratio | output | RATIO_W (6) | Bus divide ratio now in force |
| periph_ratio | output | RATIO_W (6) | Peripheral divide ratio now in force |

## Verification
Several properties are checked by assertions on every cycle:
- Each lane counter stays below its ratio.
- A strobe never repeats on the next cycle when the ratio is above 1.
- Every control write is followed by all three strobes together.
- ST_WAIT keeps the strobes quiet.
- Spare writes leave the control register and ratios untouched.
- Ratios are legal for the PLL setting.

Other behaviour only the directed scenarios can show: the exact table value for every code in each field, the exact spacing of pulses over whole periods, the reset register value, and that a spare write leaves the strobe phase running uninterrupted.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int CODE_W = 3;
    localparam int DIV_W  = 4;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    // Divider map shared by the core and bus fields
    function automatic logic [DIV_W-1:0] fast_div(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] d;
        unique case (code)
            3'd0:    d = 4'd1;
            3'd1:    d = 4'd2;
            3'd2:    d = 4'd3;
            3'd3:    d = 4'd4;
            3'd4:    d = 4'd5;
            default: d = 4'd8;
        endcase
        return d;
    endfunction

    // Divider map of the peripheral field
    function automatic logic [DIV_W-1:0] periph_div(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] d;
        unique case (code)
            3'd0:    d = 4'd2;
            3'd1:    d = 4'd3;
            3'd2:    d = 4'd4;
            3'd3:    d = 4'd6;
            default: d = 4'd8;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clkgen_seq.sv
module clkgen_seq
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic run
);

    gen_state_e state_q;
    gen_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Next state: WAIT_TO_RUN, RUN_HOLD
    always_comb begin
        unique case (state_q)
            ST_WAIT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_WAIT: run = 1'b0;
            ST_RUN:  run = 1'b1;
        endcase
    end

    AST_WAIT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> run); // R1

endmodule

// File: rtl/clkgen_regs.sv
module clkgen_regs
    import clkgen_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int PLL_BIT   = 10,
    parameter int N_DOM     = 3,
    parameter int CORE_LSB  = 6,
    parameter int BUS_LSB   = 3,
    parameter int PER_LSB   = 0,
    parameter logic [DATA_W-1:0] CTRL_RST = 'h0E0A
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic [N_DOM-1:0][CODE_W-1:0]   codes,
    output logic                           pll_on,
    output logic                           ctrl_wr
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] ctrl_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == CTRL_ADDR) ? CTRL_RST : '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign ctrl_w  = mem[CTRL_A];
    assign rd_data = mem[rd_addr];
    assign pll_on  = ctrl_w[PLL_BIT];
    assign ctrl_wr = wr_en && (wr_addr == CTRL_A);

    for (genvar d = 0; d < N_DOM; d++) begin : g_field
        localparam int LSB = (d == 0) ? CORE_LSB : (d == 1) ? BUS_LSB : PER_LSB;
        assign codes[d] = ctrl_w[LSB +: CODE_W];
    end

    AST_SPARE_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_A) |=> $stable(ctrl_w)); // R8

    AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_w == $past(wr_data)); // R7

endmodule

// File: rtl/clkgen_ratio_dec.sv
module clkgen_ratio_dec
    import clkgen_pkg::*;
#(
    parameter int RATIO_W    = 6,
    parameter int PRESCALE   = 6,
    parameter bit PERIPH_TBL = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  code,
    input  logic               pll_on,
    output logic [RATIO_W-1:0] ratio
);

    logic [DIV_W-1:0] base;

    if (PERIPH_TBL) begin : g_periph
        assign base = periph_div(code);
    end else begin : g_fast
        assign base = fast_div(code);
    end

    assign ratio = pll_on ? RATIO_W'(base) : RATIO_W'(base * PRESCALE);

    AST_PRESCALED_MULT: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |-> (ratio != '0 && (ratio % RATIO_W'(PRESCALE)) == '0)); // R5

    AST_DIRECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_on |-> (ratio >= RATIO_W'(1) && ratio <= RATIO_W'(8))); // R2

endmodule

// File: rtl/clkgen_lane.sv
module clkgen_lane #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clr,
    input  logic [RATIO_W-1:0] ratio,
    output logic               stb
);

    logic [RATIO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)                       cnt_q <= '0;
        else if (cnt_q >= ratio - RATIO_W'(1))   cnt_q <= '0;
        else                                     cnt_q <= cnt_q + RATIO_W'(1);
    end

    assign stb = run && (cnt_q == '0);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio); // R6

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ratio > RATIO_W'(1) && !clr) |=> !stb); // R6

endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
    import clkgen_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int PLL_BIT   = 10,
    parameter int PRESCALE  = 6,
    parameter int RATIO_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               core_stb,
    output logic               bus_stb,
    output logic               periph_stb,
    output logic [RATIO_W-1:0] core_ratio,
    output logic [RATIO_W-1:0] bus_ratio,
    output logic [RATIO_W-1:0] periph_ratio
);

    localparam int N_DOM = 3;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic                          run;
    logic                          ctrl_wr;
    logic                          pll_on;
    logic                          clr;
    logic [N_DOM-1:0][CODE_W-1:0]  codes;
    logic [N_DOM-1:0][RATIO_W-1:0] ratio_a;
    logic [N_DOM-1:0]              stb_a;

    clkgen_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    clkgen_regs #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .PLL_BIT   (PLL_BIT),
        .N_DOM     (N_DOM)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .codes   (codes),
        .pll_on  (pll_on),
        .ctrl_wr (ctrl_wr)
    );

    // Counters restart together while waiting and on every control write
    assign clr = !run || ctrl_wr;

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        clkgen_ratio_dec #(
            .RATIO_W    (RATIO_W),
            .PRESCALE   (PRESCALE),
            .PERIPH_TBL (d == N_DOM - 1)
        ) u_dec (
            .clk    (clk),
            .rst_n  (rst_n),
            .code   (codes[d]),
            .pll_on (pll_on),
            .ratio  (ratio_a[d])
        );

        clkgen_lane #(
            .RATIO_W (RATIO_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .clr   (clr),
            .ratio (ratio_a[d]),
            .stb   (stb_a[d])
        );
    end

    assign core_stb     = stb_a[0];
    assign bus_stb      = stb_a[1];
    assign periph_stb   = stb_a[2];
    assign core_ratio   = ratio_a[0];
    assign bus_ratio    = ratio_a[1];
    assign periph_ratio = ratio_a[2];

    AST_RESYNC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (core_stb && bus_stb && periph_stb)); // R7

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (stb_a == '0)); // R1

    AST_SPARE_NO_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_A) |=> $stable(ratio_a)); // R8

endmodule

// File: tb/tb_clk_ratio_gen.sv
module tb_clk_ratio_gen;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 2;
    localparam int RW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          core_stb, bus_stb, periph_stb;
    logic [RW-1:0] core_ratio, bus_ratio, periph_ratio;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int exp_c  = 1;
    int exp_b  = 2;
    int exp_p  = 4;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clk_ratio_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .core_stb     (core_stb),
        .bus_stb      (bus_stb),
        .periph_stb   (periph_stb),
        .core_ratio   (core_ratio),
        .bus_ratio    (bus_ratio),
        .periph_ratio (periph_ratio)
    );

    function automatic int tb_fast(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 5;
            default: return 8;
        endcase
    endfunction

    function automatic int tb_per(input int code);
        case (code)
            0: return 2;
            1: return 3;
            2: return 4;
            3: return 6;
            default: return 8;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare strobes for the current phase k, then advance
    task automatic sample(input string tag);
        check({tag, " core_stb"},   int'(core_stb),   int'((k % exp_c) == 0));
        check({tag, " bus_stb"},    int'(bus_stb),    int'((k % exp_b) == 0));
        check({tag, " periph_stb"}, int'(periph_stb), int'((k % exp_p) == 0));
        k++;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample(tag);
        end
    endtask

    function automatic logic [DW-1:0] ctrl_word(input int pll, input int c, input int b, input int p);
        return DW'((pll << 10) | (c << 6) | (b << 3) | p);
    endfunction

    // Called at a negedge; the first sample after it is the cycle after the write
    task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] v);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == '0) begin
            int pm;
            pm = v[10] ? 1 : 6;
            exp_c = pm * tb_fast(int'(v[8:6]));
            exp_b = pm * tb_fast(int'(v[5:3]));
            exp_p = pm * tb_per(int'(v[2:0]));
            k = 0;
            sample("R7");
        end else begin
            sample("R8");
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        rd_addr = 2'd0;
        #1;
        check("R1 ctrl reset", int'(rd_data), 'h0E0A);
        check("R1 core_ratio", int'(core_ratio), 1);
        check("R1 bus_ratio", int'(bus_ratio), 2);
        check("R1 periph_ratio", int'(periph_ratio), 4);
        check("R1 wait strobes", int'({core_stb, bus_stb, periph_stb}), 0);
        rd_addr = 2'd2;
        #1;
        check("R9 spare reset", int'(rd_data), 0);
        exp_c = 1; exp_b = 2; exp_p = 4; k = 0;
        run(9, "R1");
    endtask

    task automatic t_core_table();
        for (int c = 0; c < 8; c++) begin
            write_reg(2'd0, ctrl_word(1, c, 0, 0));
            check("R2 core_ratio", int'(core_ratio), tb_fast(c));
            run(10, "R6");
        end
    endtask

    task automatic t_bus_table();
        for (int b = 0; b < 8; b++) begin
            write_reg(2'd0, ctrl_word(1, 0, b, 0));
            check("R3 bus_ratio", int'(bus_ratio), tb_fast(b));
            run(10, "R6");
        end
    endtask

    task automatic t_periph_table();
        for (int p = 0; p < 8; p++) begin
            write_reg(2'd0, ctrl_word(1, 0, 0, p));
            check("R4 periph_ratio", int'(periph_ratio), tb_per(p));
            run(10, "R6");
        end
    endtask

    task automatic t_pll_off();
        write_reg(2'd0, ctrl_word(0, 2, 4, 3));
        check("R5 core_ratio", int'(core_ratio), 18);
        check("R5 bus_ratio", int'(bus_ratio), 30);
        check("R5 periph_ratio", int'(periph_ratio), 36);
        run(75, "R6");
        write_reg(2'd0, ctrl_word(0, 0, 7, 0));
        check("R5 core_ratio min", int'(core_ratio), 6);
        check("R5 bus_ratio max", int'(bus_ratio), 48);
        check("R5 periph_ratio", int'(periph_ratio), 12);
        run(100, "R6");
    endtask

    task automatic t_spare();
        logic [DW-1:0] cw;
        cw = ctrl_word(1, 2, 4, 4);
        write_reg(2'd0, cw);
        run(3, "R6");
        write_reg(2'd1, 16'hBEEF);
        run(4, "R8");
        write_reg(2'd3, 16'h1234);
        run(20, "R8");
        check("R8 core_ratio kept", int'(core_ratio), 3);
        check("R8 bus_ratio kept", int'(bus_ratio), 5);
        check("R8 periph_ratio kept", int'(periph_ratio), 8);
        rd_addr = 2'd1;
        #1;
        check("R9 read spare1", int'(rd_data), 'hBEEF);
        rd_addr = 2'd3;
        #1;
        check("R9 read spare3", int'(rd_data), 'h1234);
        rd_addr = 2'd0;
        #1;
        check("R8 ctrl kept", int'(rd_data), int'(cw));
    endtask

    task automatic t_resync();
        write_reg(2'd0, ctrl_word(1, 2, 4, 3));
        run(4, "R6");
        // rewrite same value mid-phase: all strobes restart together
        write_reg(2'd0, ctrl_word(1, 2, 4, 3));
        check("R7 all high", int'({core_stb, bus_stb, periph_stb}), 7);
        run(31, "R7");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_core_table();
        t_bus_table();
        t_periph_table();
        t_pll_off();
        t_spare();
        t_resync();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule